// File: doc/BRIEF.md
# Test Coprocessor Stall and Interrupt Timer

This block is a test coprocessor that sits beside a processor core. It holds sixteen general 32-bit registers that the core writes and reads through a simple register transfer port. It also accepts data-operation commands, each carrying a 4-bit operation code and a 4-bit register index. The index picks a register whose value is used as a cycle count N.

The commands stall the core for N cycles, or lower the active-low FIQ or IRQ request line after N cycles. Two further commands raise those lines again. One more command copies a free-running cycle counter into a register, so that software can time stretches of code. Each interrupt line has its own timer, and issuing a new schedule command restarts that timer. While the core is stalled, the block ignores commands and register writes.

Top module: `testcop_timer`

## Requirements
- R1: The block holds 16 registers of DW bits, all zero after reset. A write (`wr_en`=1) stores `wr_data` into the register selected by `reg_idx` at the clock edge. `rd_data` always shows the selected register without delay.
- R2: Operation code 4'd0 ("stall") takes N from the register at `cmd_idx`. `busy` is then high for exactly N consecutive cycles, starting right after the accepting edge. When N is 0, `busy` stays low.
- R3: While `busy` is high, every command and every register write is ignored.
- R4: Operation code 4'd1 drives `fiq_n` low N clock edges after the accepting edge. When N is 0, it goes low at the accepting edge itself. The line then stays low until it is cleared.
- R5: Operation code 4'd2 does the same for `irq_n`, using a timer separate from the FIQ timer.
- R6: Operation code 4'd3 drives `fiq_n` high at the accepting edge, and operation code 4'd4 drives `irq_n` high at the accepting edge. Each affects only its own line.
- R7: A DW-bit cycle counter is cleared by reset and adds one every clock. Operation code 4'd5 writes the counter's value before the accepting edge into the register at `cmd_idx`. If this command and a register write target the same register in the same cycle, the command wins.
- R8: Operation codes 4'd6 to 4'd15 change no register, timer or output.
- R9: A schedule command (4'd1 or 4'd2) issued while that line's timer is already counting restarts the count from the new N.
- R10: After reset, `busy` is 0, `fiq_n` is 1 and `irq_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register select for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Selected register contents |
| cmd_valid | input | 1 | Data-operation command strobe |
| cmd_op | input | 4 | Operation code |
| cmd_idx | input | 4 | Register index of the command |
| busy | output | 1 | Stall request to the core |
| fiq_n | output | 1 | Active-low fast interrupt request |
| irq_n | output | 1 | Active-low normal interrupt request |

## Verification
Some properties hold on every cycle, and the assertions check them continuously. `busy` rises only after a stall command. An interrupt line rises only after its own clear command. A line falls only from its armed timer or from a zero-count schedule. The cycle counter steps by exactly one each clock.

Other behaviours need a known timeline, so only the bench scenarios can show them. These are the exact stall length and interrupt delay for a given N, the restart of a timer, the values that snapshots record, and the silence of rejected or unknown commands.

// File: rtl/testcop_timer.sv
module testcop_timer #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] reg_idx,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          cmd_valid,
  input  logic [3:0]    cmd_op,
  input  logic [IW-1:0] cmd_idx,
  output logic          busy,
  output logic          fiq_n,
  output logic          irq_n
);
  localparam logic [3:0] OP_STALL = 4'd0;
  localparam logic [3:0] OP_STAMP = 4'd5;

  logic [DW-1:0] regs [NREG];
  logic [DW-1:0] cyc;
  logic [DW-1:0] stall_rem;
  logic [DW-1:0] tmr_cnt [2];
  logic [1:0]    tmr_arm;
  logic [1:0]    int_n;
  logic          accept;
  logic [DW-1:0] n_val;

  assign accept  = cmd_valid && !busy;
  assign n_val   = regs[cmd_idx];
  assign rd_data = regs[reg_idx];
  assign busy    = stall_rem != '0;
  assign fiq_n   = int_n[0];
  assign irq_n   = int_n[1];

  always_ff @(posedge clk) begin
    if (!rst_n) cyc <= '0;
    else        cyc <= cyc + 1'b1;
  end

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs[i] <= '0;
      else if (accept && cmd_op == OP_STAMP && cmd_idx == IW'(i))
        regs[i] <= cyc;
      else if (wr_en && !busy && reg_idx == IW'(i))
        regs[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      stall_rem <= '0;
    else if (accept && cmd_op == OP_STALL)
      stall_rem <= n_val;
    else if (stall_rem != '0)
      stall_rem <= stall_rem - 1'b1;
  end

  for (genvar c = 0; c < 2; c++) begin : g_tmr
    localparam logic [3:0] OP_SCHED = 4'(1 + c);
    localparam logic [3:0] OP_CLR   = 4'(3 + c);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tmr_cnt[c] <= '0;
        tmr_arm[c] <= 1'b0;
        int_n[c]   <= 1'b1;
      end else if (accept && cmd_op == OP_SCHED) begin
        if (n_val == '0) begin
          int_n[c]   <= 1'b0;
          tmr_arm[c] <= 1'b0;
        end else begin
          tmr_cnt[c] <= n_val;
          tmr_arm[c] <= 1'b1;
        end
      end else begin
        if (accept && cmd_op == OP_CLR)
          int_n[c] <= 1'b1;
        if (tmr_arm[c]) begin
          if (tmr_cnt[c] == DW'(1)) begin
            int_n[c]   <= 1'b0;
            tmr_arm[c] <= 1'b0;
          end else begin
            tmr_cnt[c] <= tmr_cnt[c] - 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/testcop_timer_chk.sv
module testcop_timer_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [3:0]    cmd_op,
  input logic          busy,
  input logic          fiq_n,
  input logic          irq_n,
  input logic [DW-1:0] cyc,
  input logic [1:0]    tmr_arm
);
  AST_STALL_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid && cmd_op == 4'd0)); // R2
  AST_FIQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fiq_n) |-> $past(cmd_valid && !busy && cmd_op == 4'd3)); // R6
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(cmd_valid && !busy && cmd_op == 4'd4)); // R6
  AST_FIQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fiq_n) |-> $past(tmr_arm[0] || (cmd_valid && !busy && cmd_op == 4'd1))); // R4
  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_n) |-> $past(tmr_arm[1] || (cmd_valid && !busy && cmd_op == 4'd2))); // R5
  AST_CYCLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (cyc == $past(cyc) + DW'(1))); // R7
endmodule

bind testcop_timer testcop_timer_chk #(.DW(DW)) i_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .fiq_n(fiq_n), .irq_n(irq_n), .cyc(cyc), .tmr_arm(tmr_arm)
);

// File: tb/test_testcop_timer.sv
module test_testcop_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [3:0]  cmd_idx = '0;
  logic        busy, fiq_n, irq_n;
  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  testcop_timer i_testcop_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(reg_idx),
    .wr_data(wr_data), .rd_data(rd_data), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_idx(cmd_idx), .busy(busy), .fiq_n(fiq_n), .irq_n(irq_n)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] idx, logic [31:0] val);
    wr_en = 1'b1; reg_idx = idx; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] idx, output logic [31:0] val);
    reg_idx = idx; #1; val = rd_data;
  endtask

  task automatic cmd(logic [3:0] op, logic [3:0] idx);
    cmd_valid = 1'b1; cmd_op = op; cmd_idx = idx;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R10 busy", busy, 0);
    check("R10 fiq_n", fiq_n, 1);
    check("R10 irq_n", irq_n, 1);
    rd(4'd9, v);
    check("R1 reset reg", v, 0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(4'd0, 32'hA5A5_0001);
    wr(4'd15, 32'h1234_5678);
    rd(4'd0, v);  check("R1 reg0", v, 32'hA5A5_0001);
    rd(4'd15, v); check("R1 reg15", v, 32'h1234_5678);
  endtask

  task automatic t_stall(logic [31:0] n);
    int k = 0;
    wr(4'd2, n);
    cmd(4'd0, 4'd2);
    while (busy && k < 1000) begin k++; @(negedge clk); end
    check("R2 stall length", k, n);
  endtask

  task automatic t_irq_delay(bit is_irq, logic [31:0] n);
    int k = 0;
    wr(4'd4, n);
    cmd(is_irq ? 4'd2 : 4'd1, 4'd4);
    while ((is_irq ? irq_n : fiq_n) && k < 1000) begin k++; @(negedge clk); end
    check(is_irq ? "R5 irq delay" : "R4 fiq delay", k, n);
    check(is_irq ? "R6 fiq untouched" : "R6 irq untouched", is_irq ? fiq_n : irq_n, 1);
    idle(3);
    check(is_irq ? "R5 irq held" : "R4 fiq held", is_irq ? irq_n : fiq_n, 0);
    cmd(is_irq ? 4'd4 : 4'd3, 4'd0);
    check("R6 clear", is_irq ? irq_n : fiq_n, 1);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    wr(4'd7, 32'h0000_0077);
    wr(4'd2, 32'd6);
    cmd(4'd0, 4'd2);
    wr(4'd7, 32'hDEAD_BEEF);
    wr(4'd1, 32'd0);
    cmd(4'd1, 4'd1);
    cmd(4'd5, 4'd7);
    idle(4);
    check("R3 busy done", busy, 0);
    rd(4'd7, v);
    check("R3 write ignored", v, 32'h0000_0077);
    check("R3 fiq untouched", fiq_n, 1);
  endtask

  task automatic t_stamp();
    logic [31:0] a, b;
    cmd(4'd5, 4'd10);
    idle(10);
    cmd(4'd5, 4'd11);
    rd(4'd10, a); rd(4'd11, b);
    check("R7 stamp gap", b - a, 11);
    cmd(4'd5, 4'd12);
    rd(4'd12, a);
    check("R7 stamp back-to-back", a - b, 1);
    wr_en = 1'b1; reg_idx = 4'd12; wr_data = 32'h5555_5555;
    cmd(4'd5, 4'd12);
    wr_en = 1'b0;
    rd(4'd12, b);
    check("R7 stamp wins over write", b - a, 1);
  endtask

  task automatic t_unknown();
    logic [31:0] v;
    wr(4'd3, 32'd0);
    for (int op = 6; op < 16; op++) cmd(4'(op), 4'd3);
    rd(4'd3, v);
    check("R8 reg unchanged", v, 0);
    check("R8 busy", busy, 0);
    check("R8 fiq_n", fiq_n, 1);
    check("R8 irq_n", irq_n, 1);
  endtask

  task automatic t_restart();
    int k = 0;
    wr(4'd5, 32'd20);
    wr(4'd6, 32'd3);
    cmd(4'd1, 4'd5);
    idle(5);
    cmd(4'd1, 4'd6);
    while (fiq_n && k < 1000) begin k++; @(negedge clk); end
    check("R9 restart delay", k, 3);
    cmd(4'd3, 4'd0);
    idle(25);
    check("R9 old count gone", fiq_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_stall(32'd5);
    t_stall(32'd1);
    t_stall(32'd0);
    t_irq_delay(1'b0, 32'd4);
    t_irq_delay(1'b0, 32'd0);
    t_irq_delay(1'b1, 32'd7);
    t_irq_delay(1'b1, 32'd1);
    t_busy_ignore();
    t_stamp();
    t_unknown();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule